// File: doc/BRIEF.md
# Dual Timer/Counter with Selectable Count Structures

This block holds two independent 16-bit timer/counter channels. Each channel is stored as a low byte and a high byte. A processor configures and reads the block through a small byte-wide register port. A shared configuration byte chooses, for each channel, how its two bytes are chained together, where its count events come from, and whether an external level gates it. A control byte holds the run enables and the sticky overflow flags. The two flags leave the block as level outputs for an interrupt controller.

Count events come from one of two sources. The first is a machine-cycle strobe `cyc_en`, supplied by the surrounding clocking logic. The second is a falling edge on the channel's external count pin, synchronised and sampled at machine-cycle rate. There are four count structures:

- a 13-bit counter, in which the five low bits of the low byte act as a prescaler ahead of the high byte;
- a 16-bit counter;
- an 8-bit counter that reloads from the high byte;
- a split arrangement, in which channel 0's two bytes become two separate 8-bit counters.

The low nibble of the control byte has no function here. It is kept as plain read/write storage.

Top module: `tmr_dual`

## Requirements
- R1: After synchronous reset, every register reads 0 and both `ovf_irq` bits are 0.
- R2: Register addresses: 0 is the configuration byte, 1 is the control byte, 2/3 are channel 0 low/high, 4/5 are channel 1 low/high, and 6/7 read 0. A write at an address takes effect at the next clock edge, and `reg_rdata` shows the addressed register combinationally. Control bits 3..0 are plain storage.
- R3: Configuration nibble layout, most to least significant bit: gate, external, mode[1:0]. Channel 1 uses bits 7..4 and channel 0 uses bits 3..0. Mode 00 is the 13-bit structure: on each event, low bits 4..0 increment, and their wrap from 31 increments the high byte. Low bits 7..5 keep their value. The channel overflows when it wraps with the high byte at 255.
- R4: Mode 01 counts {high, low} as one 16-bit value and overflows on the wrap from 65535 to 0.
- R5: Mode 10 increments the low byte. When the low byte is at 255, an event loads the high byte into the low byte and raises an overflow. The high byte is not changed.
- R6: Mode 11 on channel 0: the low byte is an 8-bit counter under channel 0's own enables and sets flag 0 on its wrap. The high byte counts every `cyc_en` while run bit 1 is set, with no gate and no external source, and sets flag 1 on its wrap. Mode 11 on channel 1 freezes channel 1.
- R7: With external = 0, an event is a `cyc_en` cycle. With external = 1, the pin passes through two flops, and an event is a `cyc_en` cycle in which the synchronised pin is 0 and its value at the previous `cyc_en` cycle was 1.
- R8: A channel counts only while its run bit is 1 (bit 4 for channel 0, bit 6 for channel 1). If its gate bit is 1, it also needs its `ext_gate` pin, synchronised through two flops, to be 1.
- R9: Control bit 5 is flag 0 and bit 7 is flag 1, and `ovf_irq` = {bit 7, bit 5}. A flag is set one clock after its overflow and stays set until software writes 0 to it. An overflow in the same cycle as a control write leaves the flag set.
- R10: A write to either byte of a channel stores the written byte and suppresses every count in that channel for that cycle.
- R11: While channel 0 is in mode 11, overflows of channel 1 do not set flag 1. Channel 1 still counts in its own mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc_en | input | 1 | Machine-cycle strobe |
| ext_cnt | input | 2 | External count pins, one per channel |
| ext_gate | input | 2 | External gate level pins, one per channel |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Addressed register contents |
| ovf_irq | output | 2 | Overflow flags {channel 1, channel 0} |

## Verification
A wrong internal state shows up at the ports one clock after it is created. A wrong count byte is visible in `reg_rdata` the next time that address is read, and the bench rotates the address on every idle cycle, so this takes at most eight cycles. A wrong overflow decision shows up on `ovf_irq` on the following clock and stays there, because the flags are sticky. A fault in the synchroniser or the edge detector shifts a count by one event. That offset persists in the count bytes and in the time of the next overflow, so the bench sees it well before the end of a stimulus phase.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int BYTE_W      = 8;
    localparam int PRE_W       = 5;
    localparam int ADDR_W      = 3;
    localparam int NUM_CH      = 2;
    localparam int SYNC_STAGES = 2;
    localparam int NIB_W       = 4;

    typedef enum logic [1:0] {
        MD_PRE13  = 2'b00,
        MD_FULL16 = 2'b01,
        MD_RELD8  = 2'b10,
        MD_SPLIT  = 2'b11
    } tmode_e;

    typedef struct packed {
        logic   gate;
        logic   ext;
        tmode_e mode;
    } chcfg_s;

    typedef struct packed {
        logic [BYTE_W-1:0] hi;
        logic [BYTE_W-1:0] lo;
    } cnt_s;

    localparam logic [ADDR_W-1:0] A_CFG  = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(1);

    localparam int B_FLAG1 = 7;
    localparam int B_RUN1  = 6;
    localparam int B_FLAG0 = 5;
    localparam int B_RUN0  = 4;

    function automatic logic [ADDR_W-1:0] lo_addr(input int ch);
        return ADDR_W'(2 + 2 * ch);
    endfunction

    function automatic logic [ADDR_W-1:0] hi_addr(input int ch);
        return ADDR_W'(3 + 2 * ch);
    endfunction

    function automatic int run_pos(input int ch);
        return (ch == 0) ? B_RUN0 : B_RUN1;
    endfunction

endpackage

// File: rtl/tmr_pin_sync.sv
module tmr_pin_sync
    import tmr_pkg::*;
#(
    parameter int STAGES = SYNC_STAGES
) (
    input  logic clk,
    input  logic rst,
    input  logic cyc_en,
    input  logic cnt_pin,
    input  logic gate_pin,
    output logic gate_lvl,
    output logic cnt_fall
);

    logic [STAGES-1:0] cnt_sh;
    logic [STAGES-1:0] gate_sh;
    logic              cnt_prev;
    logic              cnt_lvl;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_sh   <= '0;
            gate_sh  <= '0;
            cnt_prev <= 1'b0;
        end else begin
            cnt_sh  <= {cnt_sh[STAGES-2:0], cnt_pin};
            gate_sh <= {gate_sh[STAGES-2:0], gate_pin};
            if (cyc_en) begin
                cnt_prev <= cnt_lvl;
            end
        end
    end

    assign cnt_lvl  = cnt_sh[STAGES-1];
    assign gate_lvl = gate_sh[STAGES-1];
    assign cnt_fall = cyc_en & cnt_prev & ~cnt_lvl;

    // R7: a detected edge consumes the remembered high level
    assert_no_double_fall_R7: assert property (@(posedge clk) disable iff (rst)
        cnt_fall |=> !cnt_fall);

endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
    import tmr_pkg::*;
#(
    parameter bit SPLIT_OWNER = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  chcfg_s            cfg,
    input  logic              run,
    input  logic              gate_lvl,
    input  logic              cyc_en,
    input  logic              fall,
    input  logic              aux_run,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [BYTE_W-1:0] wdata,
    output cnt_s              cnt_q,
    output logic              ovf_main,
    output logic              ovf_aux
);

    localparam logic [PRE_W-1:0]  PRE_MAX  = '1;
    localparam logic [BYTE_W-1:0] BYTE_MAX = '1;

    logic evt;
    cnt_s nxt;
    cnt_s split_nxt;
    logic split_ovf_lo;
    logic split_ovf_hi;

    assign evt = run & (~cfg.gate | gate_lvl) & (cfg.ext ? fall : cyc_en);

    generate
        if (SPLIT_OWNER) begin : g_split
            always_comb begin
                split_nxt    = cnt_q;
                split_ovf_lo = 1'b0;
                split_ovf_hi = 1'b0;
                if (evt) begin
                    split_nxt.lo = cnt_q.lo + 1'b1;
                    split_ovf_lo = (cnt_q.lo == BYTE_MAX);
                end
                if (cyc_en && aux_run) begin
                    split_nxt.hi = cnt_q.hi + 1'b1;
                    split_ovf_hi = (cnt_q.hi == BYTE_MAX);
                end
            end
        end else begin : g_hold
            assign split_nxt    = cnt_q;
            assign split_ovf_lo = 1'b0;
            assign split_ovf_hi = 1'b0;

            // R6: the second channel freezes in the split mode
            assert_split_freeze_R6: assert property (@(posedge clk) disable iff (rst)
                (cfg.mode == MD_SPLIT && !wr_lo && !wr_hi) |=> $stable(cnt_q));
        end
    endgenerate

    always_comb begin
        nxt      = cnt_q;
        ovf_main = 1'b0;
        ovf_aux  = 1'b0;
        if (wr_lo || wr_hi) begin
            if (wr_lo) nxt.lo = wdata;
            if (wr_hi) nxt.hi = wdata;
        end else begin
            unique case (cfg.mode)
                MD_PRE13: begin
                    if (evt) begin
                        if (cnt_q.lo[PRE_W-1:0] == PRE_MAX) begin
                            nxt.lo[PRE_W-1:0] = '0;
                            nxt.hi            = cnt_q.hi + 1'b1;
                            ovf_main          = (cnt_q.hi == BYTE_MAX);
                        end else begin
                            nxt.lo[PRE_W-1:0] = cnt_q.lo[PRE_W-1:0] + 1'b1;
                        end
                    end
                end
                MD_FULL16: begin
                    if (evt) begin
                        nxt      = cnt_q + 1'b1;
                        ovf_main = (cnt_q == '1);
                    end
                end
                MD_RELD8: begin
                    if (evt) begin
                        if (cnt_q.lo == BYTE_MAX) begin
                            nxt.lo   = cnt_q.hi;
                            ovf_main = 1'b1;
                        end else begin
                            nxt.lo = cnt_q.lo + 1'b1;
                        end
                    end
                end
                MD_SPLIT: begin
                    nxt      = split_nxt;
                    ovf_main = split_ovf_lo;
                    ovf_aux  = split_ovf_hi;
                end
                default: nxt = cnt_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= nxt;
    end

    assert_write_lo_R10: assert property (@(posedge clk) disable iff (rst)
        wr_lo |=> cnt_q.lo == $past(wdata));

    assert_write_hi_R10: assert property (@(posedge clk) disable iff (rst)
        wr_hi |=> cnt_q.hi == $past(wdata));

    assert_pre13_wrap_R3: assert property (@(posedge clk) disable iff (rst)
        (cfg.mode == MD_PRE13 && ovf_main) |=> (cnt_q.hi == '0 && cnt_q.lo[PRE_W-1:0] == '0));

    assert_full16_wrap_R4: assert property (@(posedge clk) disable iff (rst)
        (cfg.mode == MD_FULL16 && ovf_main) |=> cnt_q == '0);

    assert_reload_R5: assert property (@(posedge clk) disable iff (rst)
        (cfg.mode == MD_RELD8 && ovf_main) |=> (cnt_q.lo == $past(cnt_q.hi) && $stable(cnt_q.hi)));

endmodule

// File: rtl/tmr_dual.sv
module tmr_dual
    import tmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cyc_en,
    input  logic [NUM_CH-1:0] ext_cnt,
    input  logic [NUM_CH-1:0] ext_gate,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [BYTE_W-1:0] reg_wdata,
    output logic [BYTE_W-1:0] reg_rdata,
    output logic [NUM_CH-1:0] ovf_irq
);

    logic [BYTE_W-1:0] cfg_q;
    logic [BYTE_W-1:0] ctrl_q;
    logic [BYTE_W-1:0] ctrl_nxt;

    chcfg_s            cfg      [NUM_CH];
    cnt_s              cnt      [NUM_CH];
    logic [NUM_CH-1:0] ovf_main;
    logic [NUM_CH-1:0] ovf_aux;
    logic [NUM_CH-1:0] gate_lvl;
    logic [NUM_CH-1:0] cnt_fall;

    logic ch0_split;
    logic set_f0;
    logic set_f1;
    logic wr_ctrl;

    generate
        for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
            assign cfg[g] = chcfg_s'(cfg_q[NIB_W*g +: NIB_W]);

            tmr_pin_sync #(.STAGES(SYNC_STAGES)) i_sync (
                .clk      (clk),
                .rst      (rst),
                .cyc_en   (cyc_en),
                .cnt_pin  (ext_cnt[g]),
                .gate_pin (ext_gate[g]),
                .gate_lvl (gate_lvl[g]),
                .cnt_fall (cnt_fall[g])
            );

            tmr_chan #(.SPLIT_OWNER(g == 0)) i_chan (
                .clk      (clk),
                .rst      (rst),
                .cfg      (cfg[g]),
                .run      (ctrl_q[run_pos(g)]),
                .gate_lvl (gate_lvl[g]),
                .cyc_en   (cyc_en),
                .fall     (cnt_fall[g]),
                .aux_run  ((g == 0) ? ctrl_q[B_RUN1] : 1'b0),
                .wr_lo    (reg_wr && reg_addr == lo_addr(g)),
                .wr_hi    (reg_wr && reg_addr == hi_addr(g)),
                .wdata    (reg_wdata),
                .cnt_q    (cnt[g]),
                .ovf_main (ovf_main[g]),
                .ovf_aux  (ovf_aux[g])
            );
        end
    endgenerate

    assign ch0_split = (cfg[0].mode == MD_SPLIT);
    assign set_f0    = ovf_main[0];
    assign set_f1    = ch0_split ? ovf_aux[0] : ovf_main[1];
    assign wr_ctrl   = reg_wr && reg_addr == A_CTRL;

    always_comb begin
        ctrl_nxt = wr_ctrl ? reg_wdata : ctrl_q;
        if (set_f0) ctrl_nxt[B_FLAG0] = 1'b1;
        if (set_f1) ctrl_nxt[B_FLAG1] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q  <= '0;
            ctrl_q <= '0;
        end else begin
            ctrl_q <= ctrl_nxt;
            if (reg_wr && reg_addr == A_CFG) cfg_q <= reg_wdata;
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == A_CFG) begin
            reg_rdata = cfg_q;
        end else if (reg_addr == A_CTRL) begin
            reg_rdata = ctrl_q;
        end else begin
            for (int c = 0; c < NUM_CH; c++) begin
                if (reg_addr == lo_addr(c)) reg_rdata = cnt[c].lo;
                if (reg_addr == hi_addr(c)) reg_rdata = cnt[c].hi;
            end
        end
    end

    assign ovf_irq = {ctrl_q[B_FLAG1], ctrl_q[B_FLAG0]};

    assert_flag0_sets_R9: assert property (@(posedge clk) disable iff (rst)
        set_f0 |=> ovf_irq[0]);

    assert_flag1_sets_R9: assert property (@(posedge clk) disable iff (rst)
        set_f1 |=> ovf_irq[1]);

    assert_flag0_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        (ovf_irq[0] && !wr_ctrl) |=> ovf_irq[0]);

    assert_flag1_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        (ovf_irq[1] && !wr_ctrl) |=> ovf_irq[1]);

    assert_split_mask_R11: assert property (@(posedge clk) disable iff (rst)
        (ch0_split && !ovf_aux[0] && !ovf_irq[1] && !wr_ctrl) |=> !ovf_irq[1]);

endmodule

// File: tb/test_tmr_dual.sv
module test_tmr_dual;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst;
    logic       cyc_en;
    logic [1:0] ext_cnt;
    logic [1:0] ext_gate;
    logic       reg_wr;
    logic [2:0] reg_addr;
    logic [7:0] reg_wdata;
    logic [7:0] reg_rdata;
    logic [1:0] ovf_irq;

    always #(CLK_PERIOD/2) clk = ~clk;

    tmr_dual i_tmr_dual (
        .clk       (clk),
        .rst       (rst),
        .cyc_en    (cyc_en),
        .ext_cnt   (ext_cnt),
        .ext_gate  (ext_gate),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .ovf_irq   (ovf_irq)
    );

    int    n_cmp = 0;
    int    n_bad = 0;
    string cur_tag = "R1";
    bit    done = 0;
    int    pin_rate = 0;

    // behavioural reference state
    int m_cfg, m_ctrl;
    int m_lo[2], m_hi[2];
    int s1[2], s2[2], pv[2], g1[2], g2[2];

    function automatic void model_reset();
        m_cfg = 0; m_ctrl = 0;
        for (int i = 0; i < 2; i++) begin
            m_lo[i] = 0; m_hi[i] = 0;
            s1[i] = 0; s2[i] = 0; pv[i] = 0; g1[i] = 0; g2[i] = 0;
        end
    endfunction

    function automatic int model_read(int a);
        case (a)
            0: return m_cfg;
            1: return m_ctrl;
            2: return m_lo[0];
            3: return m_hi[0];
            4: return m_lo[1];
            5: return m_hi[1];
            default: return 0;
        endcase
    endfunction

    function automatic void model_step(int wr, int a, int wd, int cyc, int pin0, int pin1, int gp0, int gp1);
        int nlo[2], nhi[2], pins[2], gps[2];
        int set0, set1, aux, ov1, nctrl;
        pins[0] = pin0; pins[1] = pin1; gps[0] = gp0; gps[1] = gp1;
        set0 = 0; aux = 0; ov1 = 0;
        for (int i = 0; i < 2; i++) begin
            int nib, gate, ext, md, tr, evt, edge_seen, ov;
            nib = (m_cfg >> (4 * i)) & 15;
            gate = (nib >> 3) & 1; ext = (nib >> 2) & 1; md = nib & 3;
            tr = (m_ctrl >> (i == 0 ? 4 : 6)) & 1;
            edge_seen = (cyc != 0 && pv[i] != 0 && s2[i] == 0) ? 1 : 0;
            evt = (tr != 0 && (gate == 0 || g2[i] != 0) && (ext != 0 ? edge_seen != 0 : cyc != 0)) ? 1 : 0;
            nlo[i] = m_lo[i]; nhi[i] = m_hi[i]; ov = 0;
            if (wr != 0 && (a == 2 + 2 * i || a == 3 + 2 * i)) begin
                if (a == 2 + 2 * i) nlo[i] = wd; else nhi[i] = wd;
            end else if (evt != 0 || md == 3) begin
                case (md)
                    0: if ((m_lo[i] & 31) == 31) begin
                           nlo[i] = m_lo[i] & 224;
                           nhi[i] = (m_hi[i] + 1) & 255;
                           ov = (m_hi[i] == 255);
                       end else nlo[i] = (m_lo[i] & 224) | ((m_lo[i] + 1) & 31);
                    1: begin
                           int v;
                           v = m_hi[i] * 256 + m_lo[i] + 1;
                           ov = (v == 65536);
                           v = v & 65535;
                           nhi[i] = v >> 8; nlo[i] = v & 255;
                       end
                    2: if (m_lo[i] == 255) begin nlo[i] = m_hi[i]; ov = 1; end
                       else nlo[i] = m_lo[i] + 1;
                    default: if (i == 0) begin
                        if (evt != 0) begin
                            nlo[0] = (m_lo[0] + 1) & 255;
                            ov = (m_lo[0] == 255);
                        end
                        if (cyc != 0 && ((m_ctrl >> 6) & 1) != 0) begin
                            nhi[0] = (m_hi[0] + 1) & 255;
                            aux = (m_hi[0] == 255);
                        end
                    end
                endcase
            end
            if (i == 0) set0 = ov; else ov1 = ov;
        end
        set1 = ((m_cfg & 3) == 3) ? aux : ov1;
        nctrl = (wr != 0 && a == 1) ? wd : m_ctrl;
        if (set0 != 0) nctrl = nctrl | 32;
        if (set1 != 0) nctrl = nctrl | 128;
        if (wr != 0 && a == 0) m_cfg = wd;
        m_ctrl = nctrl;
        for (int i = 0; i < 2; i++) begin
            m_lo[i] = nlo[i]; m_hi[i] = nhi[i];
            if (cyc != 0) pv[i] = s2[i];
            s2[i] = s1[i]; s1[i] = pins[i];
            g2[i] = g1[i]; g1[i] = gps[i];
        end
    endfunction

    task automatic compare();
        int exp_d, exp_f;
        exp_d = model_read(int'(reg_addr));
        exp_f = ((m_ctrl >> 6) & 2) | ((m_ctrl >> 5) & 1);
        n_cmp++;
        if (int'(reg_rdata) != exp_d) begin
            n_bad++;
            $display("FAIL %s rdata addr=%0d actual=%0h expected=%0h", cur_tag, reg_addr, reg_rdata, exp_d);
        end
        n_cmp++;
        if (int'(ovf_irq) != exp_f) begin
            n_bad++;
            $display("FAIL %s ovf_irq actual=%0b expected=%0b", cur_tag, ovf_irq, exp_f);
        end
    endtask

    task automatic step(input int wr, input int a, input int d, input int cyc);
        @(negedge clk);
        compare();
        reg_wr    = (wr != 0);
        reg_addr  = a[2:0];
        reg_wdata = d[7:0];
        cyc_en    = (cyc != 0);
        for (int i = 0; i < 2; i++) begin
            if (pin_rate > 0 && ($urandom % 100) < pin_rate) ext_cnt[i] = ~ext_cnt[i];
            if (($urandom % 8) == 0) ext_gate[i] = ~ext_gate[i];
        end
        @(posedge clk);
        model_step(wr, a, d, cyc, int'(ext_cnt[0]), int'(ext_cnt[1]), int'(ext_gate[0]), int'(ext_gate[1]));
    endtask

    task automatic run_phase(input string tag, input int cfgv, input int lo0, input int hi0,
                             input int lo1, input int hi1, input int ctrlv, input int cycles,
                             input int cyc_pct, input int ctrl_pct, input int cnt_pct, input int pins);
        cur_tag  = tag;
        pin_rate = pins;
        step(1, 1, 0, 0);
        step(1, 0, cfgv, 0);
        step(1, 2, lo0, 0);
        step(1, 3, hi0, 0);
        step(1, 4, lo1, 0);
        step(1, 5, hi1, 0);
        step(1, 1, ctrlv, 0);
        for (int k = 0; k < cycles; k++) begin
            int r, cyc;
            r = int'($urandom % 100);
            cyc = (int'($urandom % 100) < cyc_pct) ? 1 : 0;
            if (r < ctrl_pct) begin
                int v;
                v = (ctrlv & 8'h5F) | ((($urandom % 8) == 0) ? int'($urandom & 8'hA0) : 0);
                step(1, 1, v, cyc);
            end else if (r < ctrl_pct + cnt_pct) begin
                step(1, 2 + int'($urandom % 4), int'($urandom % 256), cyc);
            end else begin
                step(0, k % 8, 0, cyc);
            end
        end
    endtask

    initial begin
        rst = 1'b1; cyc_en = 1'b0; ext_cnt = 2'b00; ext_gate = 2'b00;
        reg_wr = 1'b0; reg_addr = 3'd0; reg_wdata = 8'd0;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        model_reset();

        // R1: reset contents of every address
        cur_tag = "R1";
        for (int a = 0; a < 8; a++) step(0, a, 0, 0);
        step(0, 0, 0, 0);

        // R2: register map and plain storage bits
        cur_tag = "R2";
        step(1, 0, 8'h5A, 1);
        step(1, 1, 8'h0F, 1);
        step(1, 2, 8'h11, 1);
        step(1, 3, 8'h22, 1);
        step(1, 4, 8'h33, 1);
        step(1, 5, 8'h44, 1);
        for (int a = 0; a < 8; a++) step(0, a, 0, 1);
        step(1, 1, 8'hA6, 0);
        for (int a = 0; a < 8; a++) step(0, a, 0, 0);

        run_phase("R3", 8'h00, 8'hE0, 8'hFE, 8'h1C, 8'hFF, 8'h50, 400, 100, 3, 0, 0);
        run_phase("R4", 8'h11, 8'hF0, 8'hFF, 8'hE0, 8'hFF, 8'h50, 400, 70, 3, 0, 0);
        run_phase("R5", 8'h22, 8'hF0, 8'hF0, 8'hFA, 8'h80, 8'h50, 400, 70, 3, 0, 0);
        run_phase("R7", 8'h66, 8'hF8, 8'hFC, 8'hFA, 8'hF0, 8'h50, 600, 60, 3, 0, 40);
        run_phase("R7", 8'h55, 8'hF0, 8'hFF, 8'hF8, 8'hFF, 8'h50, 600, 100, 3, 0, 30);
        run_phase("R8", 8'hAA, 8'hF0, 8'hF0, 8'hF0, 8'hF0, 8'h50, 600, 80, 3, 0, 0);
        run_phase("R8", 8'h22, 8'hF0, 8'hF0, 8'hF0, 8'hF0, 8'h10, 300, 80, 3, 0, 0);
        run_phase("R6", 8'h33, 8'hF0, 8'hE0, 8'h12, 8'h34, 8'h50, 600, 80, 3, 0, 0);
        run_phase("R6", 8'h3B, 8'hF0, 8'hE0, 8'h12, 8'h34, 8'h10, 300, 80, 3, 0, 0);
        run_phase("R11", 8'h13, 8'hF0, 8'h10, 8'hF0, 8'hFF, 8'h50, 400, 90, 3, 0, 0);
        run_phase("R9", 8'h21, 8'hFE, 8'hFE, 8'hFE, 8'hFF, 8'h50, 600, 90, 30, 0, 0);
        run_phase("R10", 8'h12, 8'hF0, 8'hFF, 8'hFC, 8'hF8, 8'h50, 600, 90, 3, 30, 0);
        run_phase("R10", 8'h30, 8'hF0, 8'hFF, 8'hE0, 8'hFF, 8'h50, 400, 90, 3, 30, 0);

        @(negedge clk);
        compare();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_bad++;
            $display("FAIL %s watchdog actual=running expected=finished", cur_tag);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule